// File: doc/BRIEF.md
# Background Debug Entry Controller

This block decides when a processor core is placed in the active background debug state. A hardware debug command can write a byte to the debug status location; one bit of that byte is a firmware-enable flag. Entry into the active state is allowed only while that flag is set. Three sources can ask for entry: a hardware BACKGROUND command from the serial debug link, a hit from the instruction tagging logic, and a software BGND instruction executed by the core. Each source has its own timing. A BACKGROUND command waits for the next instruction boundary. A tag hit or a BGND instruction enters at once, before the tagged instruction runs.

A request made while the flag is clear does not enter the active state. The block instead holds a busy indication for a fixed stall window, pulses a resume signal in the window's last cycle, and lets the core continue. While the block is active it raises a freeze line for peripherals that stop during debug. It also decodes bus addresses issued by the debug logic into a register-window select for the small register block and a ROM-window select for the rest of the debug page. A GO-style exit command leaves the active state at the next instruction boundary. After reset the block is in the normal state with the flag clear, unless the special single-chip mode pin is high. In that case it comes out of reset already enabled and active.

States: IDLE (normal execution), PEND (BACKGROUND command received, waiting for a boundary), ACTIVE (in debug), EXIT (GO received, waiting for a boundary), STALL (unenabled request, timed resume). Transitions:
- IDLE to ACTIVE on a tag hit or BGND with the flag set.
- IDLE to PEND on a BACKGROUND command with the flag set.
- IDLE to STALL on any of these requests with the flag clear.
- PEND to ACTIVE or STALL, chosen by the flag, on a boundary or a tag hit.
- ACTIVE to EXIT on GO.
- EXIT to IDLE on a boundary.
- STALL to IDLE when the window ends.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: A hardware write (`wr_stb`) to address 0xFF01 loads bit 7 of `wr_data` into the enable flag, in any state. Writes to any other address leave the flag unchanged.
- R2: In IDLE with the flag clear, a tag hit, BGND or BACKGROUND command never raises `dbg_active`. From the next cycle, `busy` is high for exactly 16 cycles, `resume` is high only in the last of them, and the block then returns to IDLE.
- R3: In IDLE with the flag set, a tag hit makes `dbg_active` high in the following cycle.
- R4: In IDLE with the flag set, a BGND instruction strobe makes `dbg_active` high in the following cycle.
- R5: A BACKGROUND command with the flag set waits for an `insn_boundary` strobe in a later cycle. A boundary in the same cycle as the command does not count. `dbg_active` rises in the cycle after that boundary, or in the cycle after a tag hit during the wait, whichever comes first.
- R6: `go_cmd` while active keeps `dbg_active` high until an `insn_boundary` strobe in a later cycle. `dbg_active` falls in the cycle after that boundary.
- R7: With `rst` high at a clock edge, `special_mode` low gives flag clear and inactive, and `special_mode` high gives flag set and active.
- R8: `freeze` is high exactly while `dbg_active` is high.
- R9: `reg_win_sel` is high only when active, `dbg_access` is high and `bus_addr` is 0xFF00..0xFF06. `rom_win_sel` is high only when active, `dbg_access` is high and `bus_addr` is 0xFF07..0xFFFF. With `dbg_access` low (user access), neither is ever high.
- R10: Requests that arrive while busy, active or exiting are ignored, and `busy` and `dbg_active` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| special_mode | input | 1 | Mode pin: high selects special single-chip start |
| wr_stb | input | 1 | Hardware debug byte-write strobe |
| wr_addr | input | 16 | Address of the hardware byte write |
| wr_data | input | 8 | Data of the hardware byte write |
| bg_cmd | input | 1 | Hardware BACKGROUND command strobe |
| go_cmd | input | 1 | Exit (GO) command strobe |
| tag_hit | input | 1 | Instruction tag hit strobe |
| bgnd_insn | input | 1 | Software BGND instruction strobe |
| insn_boundary | input | 1 | Instruction boundary strobe |
| dbg_access | input | 1 | High when the bus access comes from debug logic |
| bus_addr | input | 16 | Bus address to decode |
| dbg_active | output | 1 | Active background debug state |
| freeze | output | 1 | Peripheral freeze request |
| reg_win_sel | output | 1 | Debug register window select |
| rom_win_sel | output | 1 | Debug ROM window select |
| busy | output | 1 | Timed-resume stall in progress |
| resume | output | 1 | One-cycle release at the end of the stall |

## Verification
A wrong state shows at the ports within one cycle. A state mixed up between PEND and ACTIVE, or between EXIT and IDLE, makes `dbg_active` and `freeze` differ from the reference in the very next cycle. A miscounted stall window shows in the cycle where `busy` or `resume` should change. A lost or stale enable flag shows in the cycle after the next request, as STALL taken instead of ACTIVE or the other way round. The bench compares every output on every clock against a behavioural model. It therefore catches these faults at the first differing cycle, across directed corner cases and a long pseudo-random stretch of stimulus.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PEND   = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_EXIT   = 3'd3,
        ST_STALL  = 3'd4
    } dbg_state_e;

    localparam int unsigned DBG_ADDR_W = 16;
    localparam int unsigned DBG_DATA_W = 8;

    function automatic logic is_debug_state(input dbg_state_e s);
        return (s == ST_ACTIVE) || (s == ST_EXIT);
    endfunction

endpackage

// File: rtl/dbg_enable_reg.sv
module dbg_enable_reg #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFF01,
    parameter int unsigned EN_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en_q
);

    logic hit;
    logic unused_data;

    assign hit         = wr_stb && (wr_addr == STAT_ADDR);
    assign unused_data = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= special_mode;
        end else if (hit) begin
            en_q <= wr_data[EN_BIT];
        end
    end

endmodule

// File: rtl/dbg_stall_timer.sv
module dbg_stall_timer #(
    parameter int unsigned STALL_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (STALL_CYC > 1) ? $clog2(STALL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STALL_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/dbg_window_dec.sv
module dbg_window_dec #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFF00,
    parameter logic [ADDR_W-1:0] REG_LAST = 16'hFF06
) (
    input  logic              active,
    input  logic              dbg_access,
    input  logic [ADDR_W-1:0] addr,
    output logic              reg_sel,
    output logic              rom_sel
);

    logic in_page;
    logic in_regs;

    always_comb begin
        in_page = (addr >= WIN_BASE);
        in_regs = in_page && (addr <= REG_LAST);
        reg_sel = active && dbg_access && in_regs;
        rom_sel = active && dbg_access && in_page && !in_regs;
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int unsigned ADDR_W    = DBG_ADDR_W,
    parameter int unsigned DATA_W    = DBG_DATA_W,
    parameter int unsigned STALL_CYC = 16,
    parameter int unsigned EN_BIT    = 7,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFF01,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFF00,
    parameter logic [ADDR_W-1:0] REG_LAST  = 16'hFF06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bg_cmd,
    input  logic              go_cmd,
    input  logic              tag_hit,
    input  logic              bgnd_insn,
    input  logic              insn_boundary,
    input  logic              dbg_access,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              dbg_active,
    output logic              freeze,
    output logic              reg_win_sel,
    output logic              rom_win_sel,
    output logic              busy,
    output logic              resume
);

    dbg_state_e state;
    dbg_state_e state_d;
    logic       en_q;
    logic       stall_start;
    logic       stall_done;

    dbg_enable_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STAT_ADDR(STAT_ADDR),
        .EN_BIT   (EN_BIT)
    ) u_en (
        .clk         (clk),
        .rst         (rst),
        .special_mode(special_mode),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .en_q        (en_q)
    );

    dbg_stall_timer #(
        .STALL_CYC(STALL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(stall_start),
        .run  (state == ST_STALL),
        .done (stall_done)
    );

    dbg_window_dec #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .REG_LAST(REG_LAST)
    ) u_win (
        .active    (dbg_active),
        .dbg_access(dbg_access),
        .addr      (bus_addr),
        .reg_sel   (reg_win_sel),
        .rom_sel   (rom_win_sel)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= special_mode ? ST_ACTIVE : ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (tag_hit || bgnd_insn) begin
                    state_d = en_q ? ST_ACTIVE : ST_STALL;
                end else if (bg_cmd) begin
                    state_d = en_q ? ST_PEND : ST_STALL;
                end
            end
            ST_PEND: begin
                if (tag_hit || insn_boundary) begin
                    state_d = en_q ? ST_ACTIVE : ST_STALL;
                end
            end
            ST_ACTIVE: begin
                if (go_cmd) begin
                    state_d = ST_EXIT;
                end
            end
            ST_EXIT: begin
                if (insn_boundary) begin
                    state_d = ST_IDLE;
                end
            end
            ST_STALL: begin
                if (stall_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stall_start = (state_d == ST_STALL) && (state != ST_STALL);
        dbg_active  = is_debug_state(state);
        freeze      = dbg_active;
        busy        = (state == ST_STALL);
        resume      = busy && stall_done;
    end

endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk
    import dbg_entry_pkg::*;
#(
    parameter int unsigned STALL_CYC = 16
) (
    input logic       clk,
    input logic       rst,
    input dbg_state_e state,
    input logic       en_q,
    input logic       bg_cmd,
    input logic       tag_hit,
    input logic       bgnd_insn,
    input logic       insn_boundary,
    input logic       dbg_active,
    input logic       freeze,
    input logic       reg_win_sel,
    input logic       rom_win_sel,
    input logic       busy
);

    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else begin
            run <= busy ? run + 32'd1 : 32'd0;
        end
    end

    // R2: flag clear and not active means no entry on the next edge
    a_r2_no_entry_unenabled: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !dbg_active) |=> !dbg_active);

    // R2: the stall window never exceeds its length
    a_r2_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < 32'(STALL_CYC)));

    // R2: the stall window ends exactly at its length
    a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(run) == 32'(STALL_CYC - 1)));

    // R3: an enabled tag hit in IDLE enters on the next edge
    a_r3_tag_enters: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tag_hit && en_q) |=> dbg_active);

    // R5: a BACKGROUND command alone does not enter on the next edge
    a_r5_cmd_waits: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && bg_cmd && !tag_hit && !bgnd_insn) |=> !dbg_active);

    // R6: active state is left only through a boundary
    a_r6_hold_until_boundary: assert property (@(posedge clk) disable iff (rst)
        (dbg_active && !insn_boundary) |=> dbg_active);

    // R8: freeze follows the active state
    a_r8_freeze_match: assert property (@(posedge clk) disable iff (rst)
        freeze == dbg_active);

    // R9: window selects are exclusive and only while active
    a_r9_window_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_win_sel, rom_win_sel}) && ((reg_win_sel || rom_win_sel) -> dbg_active));

    // R10: busy and active never overlap
    a_r10_busy_not_active: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dbg_active);

endmodule

bind dbg_entry_ctrl dbg_entry_chk #(
    .STALL_CYC(STALL_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .state        (state),
    .en_q         (en_q),
    .bg_cmd       (bg_cmd),
    .tag_hit      (tag_hit),
    .bgnd_insn    (bgnd_insn),
    .insn_boundary(insn_boundary),
    .dbg_active   (dbg_active),
    .freeze       (freeze),
    .reg_win_sel  (reg_win_sel),
    .rom_win_sel  (rom_win_sel),
    .busy         (busy)
);

// File: tb/test_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module test_dbg_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        special_mode = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        bg_cmd = 1'b0;
    logic        go_cmd = 1'b0;
    logic        tag_hit = 1'b0;
    logic        bgnd_insn = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        dbg_access = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        dbg_active, freeze, reg_win_sel, rom_win_sel, busy, resume;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // model: mode 0 idle, 1 waiting for boundary, 2 in debug, 3 leaving, 4 stalled
    int m_mode = 0;
    int m_left = 0;
    bit m_en = 0;

    always #2 clk = ~clk;

    dbg_entry_ctrl i_dbg_entry_ctrl (
        .clk(clk), .rst(rst), .special_mode(special_mode),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .bg_cmd(bg_cmd), .go_cmd(go_cmd), .tag_hit(tag_hit),
        .bgnd_insn(bgnd_insn), .insn_boundary(insn_boundary),
        .dbg_access(dbg_access), .bus_addr(bus_addr),
        .dbg_active(dbg_active), .freeze(freeze),
        .reg_win_sel(reg_win_sel), .rom_win_sel(rom_win_sel),
        .busy(busy), .resume(resume)
    );

    task automatic model_step();
        bit next_en;
        if (rst) begin
            m_en   = special_mode;
            m_mode = special_mode ? 2 : 0;
            m_left = 0;
            return;
        end
        next_en = m_en;
        if (wr_stb && wr_addr == 16'hFF01) next_en = wr_data[7];
        case (m_mode)
            0: begin
                if (tag_hit || bgnd_insn) begin
                    if (m_en) m_mode = 2; else begin m_mode = 4; m_left = 16; end
                end else if (bg_cmd) begin
                    if (m_en) m_mode = 1; else begin m_mode = 4; m_left = 16; end
                end
            end
            1: if (tag_hit || insn_boundary) begin
                if (m_en) m_mode = 2; else begin m_mode = 4; m_left = 16; end
            end
            2: if (go_cmd) m_mode = 3;
            3: if (insn_boundary) m_mode = 0;
            default: begin
                m_left = m_left - 1;
                if (m_left == 0) m_mode = 0;
            end
        endcase
        m_en = next_en;
    endtask

    task automatic compare(input string tag);
        bit e_act, e_busy, e_res, e_reg, e_rom;
        e_act  = (m_mode == 2) || (m_mode == 3);
        e_busy = (m_mode == 4);
        e_res  = e_busy && (m_left == 1);
        e_reg  = e_act && dbg_access && bus_addr >= 16'hFF00 && bus_addr <= 16'hFF06;
        e_rom  = e_act && dbg_access && bus_addr >= 16'hFF07;
        vectors++;
        if (dbg_active !== e_act || freeze !== e_act || busy !== e_busy ||
            resume !== e_res || reg_win_sel !== e_reg || rom_win_sel !== e_rom) begin
            miscompares++;
            $display("FAIL %s t=%0t act/frz/busy/res/reg/rom got %b%b%b%b%b%b exp %b%b%b%b%b%b",
                     tag, $time, dbg_active, freeze, busy, resume, reg_win_sel, rom_win_sel,
                     e_act, e_act, e_busy, e_res, e_reg, e_rom);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_strobes();
        wr_stb = 0; bg_cmd = 0; go_cmd = 0; tag_hit = 0; bgnd_insn = 0; insn_boundary = 0;
    endtask

    task automatic write_flag(input logic [15:0] a, input logic [7:0] d, input string tag);
        wr_stb = 1; wr_addr = a; wr_data = d;
        tick(tag);
        clear_strobes();
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic do_reset(input bit sm, input string tag);
        clear_strobes();
        special_mode = sm;
        rst = 1;
        idle(3, tag);
        rst = 0;
        idle(1, tag);
    endtask

    initial begin
        @(negedge clk);
        // R7: normal-mode reset
        do_reset(0, "R7");

        // R2: unenabled BACKGROUND command and tag hit stall, no entry
        bg_cmd = 1; tick("R2"); clear_strobes();
        idle(18, "R2");
        tag_hit = 1; tick("R2"); clear_strobes();
        // R10: requests during the stall are ignored
        bgnd_insn = 1; tick("R10"); clear_strobes();
        tag_hit = 1; tick("R10"); clear_strobes();
        idle(16, "R10");

        // R1: write to a different address leaves the flag clear
        write_flag(16'hFF02, 8'h80, "R1");
        bgnd_insn = 1; tick("R1"); clear_strobes();
        idle(17, "R1");
        // R1: write bit 7 at 0xFF01 sets the flag
        write_flag(16'hFF01, 8'h80, "R1");

        // R3: tag hit enters next cycle
        tag_hit = 1; tick("R3"); clear_strobes();
        idle(2, "R3");
        // R6: GO with boundary in the same cycle does not exit yet
        go_cmd = 1; insn_boundary = 1; tick("R6"); clear_strobes();
        idle(3, "R6");
        insn_boundary = 1; tick("R6"); clear_strobes();
        idle(2, "R6");

        // R4: BGND enters next cycle
        bgnd_insn = 1; tick("R4"); clear_strobes();
        // R9 / R8: window decode sweep
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: bus_addr = 16'hFF00;
                1: bus_addr = 16'hFF06;
                2: bus_addr = 16'hFF07;
                3: bus_addr = 16'hFFFF;
                4: bus_addr = 16'hFEFF;
                default: bus_addr = 16'h0000;
            endcase
            dbg_access = 1; tick("R9");
            dbg_access = 0; tick("R9");
        end
        // R10: requests while active ignored
        bg_cmd = 1; tag_hit = 1; tick("R10"); clear_strobes();
        go_cmd = 1; tick("R6"); clear_strobes();
        insn_boundary = 1; tick("R6"); clear_strobes();
        idle(1, "R8");

        // R5: command with same-cycle boundary waits for a later boundary
        bg_cmd = 1; insn_boundary = 1; tick("R5"); clear_strobes();
        idle(4, "R5");
        insn_boundary = 1; tick("R5"); clear_strobes();
        idle(1, "R5");
        go_cmd = 1; tick("R6"); clear_strobes();
        insn_boundary = 1; tick("R6"); clear_strobes();
        // R5: tag hit while waiting enters early
        bg_cmd = 1; tick("R5"); clear_strobes();
        idle(2, "R5");
        tag_hit = 1; tick("R5"); clear_strobes();
        idle(1, "R5");

        // R1: flag cleared while active; active state kept, next request stalls
        write_flag(16'hFF01, 8'h7F, "R1");
        go_cmd = 1; tick("R6"); clear_strobes();
        insn_boundary = 1; tick("R6"); clear_strobes();
        tag_hit = 1; tick("R1"); clear_strobes();
        idle(17, "R2");

        // R7: special-mode reset starts enabled and active
        do_reset(1, "R7");
        go_cmd = 1; tick("R7"); clear_strobes();
        insn_boundary = 1; tick("R7"); clear_strobes();
        tag_hit = 1; tick("R7"); clear_strobes();
        idle(1, "R7");
        do_reset(0, "R7");

        // R10: pseudo-random stimulus against the model
        for (int n = 0; n < 3000; n++) begin
            wr_stb        = ($urandom_range(0, 39) == 0);
            wr_addr       = ($urandom_range(0, 3) == 0) ? 16'hFF00 : 16'hFF01;
            wr_data       = 8'($urandom_range(0, 255));
            bg_cmd        = ($urandom_range(0, 15) == 0);
            go_cmd        = ($urandom_range(0, 9) == 0);
            tag_hit       = ($urandom_range(0, 23) == 0);
            bgnd_insn     = ($urandom_range(0, 23) == 0);
            insn_boundary = ($urandom_range(0, 3) == 0);
            dbg_access    = ($urandom_range(0, 1) == 1);
            bus_addr      = ($urandom_range(0, 1) == 1) ? (16'hFF00 + 16'($urandom_range(0, 255)))
                                                        : 16'($urandom_range(0, 65535));
            tick("R10");
        end
        clear_strobes();

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL R10 watchdog expired got running exp done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule